// File: doc/BRIEF.md
# Lockdown-Aware Cache Victim Pointer

This block picks the line to replace next in each segment of a segmented cache whose lowest lines can be locked. It keeps one lockdown base per cache side, shared by all segments of that side, and one victim pointer per segment. The instruction side and the data side have separate copies with identical behaviour, chosen by a side input on the command port. The cache arrays themselves are outside the block. Each victim pointer is presented on the output continuously.

Software reaches the block through a small command port. One command reads back the base. One command writes the base and loads every victim pointer of that side with the same value. A third command loads the victim pointer of a single segment and leaves the base alone.

A segment's pointer steps through a linear feedback sequence on each replacement event for that segment. In normal mode those events are linefills. In test mode they are CAM reads only, so a test routine can predict exactly which line is chosen. A generated index that falls inside the locked region is folded back into the unlocked lines, so a step never picks a locked line.

Top module: `lockdown_victim_ptr`

## Requirements
- R1: After reset, the base of both sides is 0 and every victim pointer equals SEED (default 1).
- R2: A command with cmd_op_i = 2'b00 (read base) makes rd_valid_o high in the next cycle, with rd_data_o holding the base of the side chosen by cmd_side_i (0 = instruction, 1 = data). In every other cycle rd_valid_o is low.
- R3: A command with cmd_op_i = 2'b01 sets the base of the chosen side to cmd_data_i and loads every victim pointer of that side with cmd_data_i, both visible in the next cycle. The other side is unchanged.
- R4: A command with cmd_op_i = 2'b10 loads cmd_data_i into only the victim pointer of segment cmd_seg_i on the chosen side. The base and all other pointers are unchanged. cmd_op_i = 2'b11 changes nothing.
- R5: With test_mode_i low, the bit fill_i[side*NUM_SEG+seg] steps that pointer one position in the next cycle, and cam_rd_i has no effect.
- R6: With test_mode_i high, the bit cam_rd_i[side*NUM_SEG+seg] steps that pointer, and fill_i has no effect.
- R7: A step from value p first forms raw = 1 if p is 0, and otherwise forms raw = {p[IDX_W-2:0], parity(p & TAPS)}. TAPS defaults to 6'h30, which is the polynomial x^6+x^5+1.
- R8: If raw is below the base, the new pointer is base + (raw mod (2^IDX_W - base)). Otherwise the new pointer is raw. A stepped pointer is therefore never below the base.
- R9: When a command loads a pointer in the same cycle as a replacement event for that pointer, the loaded value wins and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 read base, 01 write victim and base, 10 write one segment's victim, 11 no operation |
| cmd_side_i | input | 1 | Side select: 0 instruction, 1 data |
| cmd_seg_i | input | SEG_W | Segment for the single-segment write |
| cmd_data_i | input | IDX_W | Write data (base and/or victim index) |
| test_mode_i | input | 1 | High: step on CAM reads only; low: step on linefills |
| fill_i | input | 2*NUM_SEG | Linefill event per side and segment, bit side*NUM_SEG+seg |
| cam_rd_i | input | 2*NUM_SEG | CAM read event per side and segment, same bit layout |
| rd_valid_o | output | 1 | Base read data valid |
| rd_data_o | output | IDX_W | Base read data |
| victim_o | output | 2*NUM_SEG*IDX_W | Victim index per pointer, slice (side*NUM_SEG+seg)*IDX_W |

## Verification
The case that is hardest to reach is the fold into the unlocked range. It needs a high base and then a raw sequence value that lands below it, and after reset the sequence only climbs slowly through small values. The stimulus therefore writes high bases (40, 63, and random values biased above 48) and then applies bursts of events. It also loads zero or other values below the base into single segments, which covers the zero escape and the fold together. Loads that coincide with events, and events of the wrong kind for the current mode, are mixed into the random phase. This checks that each step is dropped or ignored as required.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [1:0] {
    OP_RD_BASE = 2'b00,
    OP_WR_ALL  = 2'b01,
    OP_WR_SEG  = 2'b10,
    OP_NOP     = 2'b11
  } cmd_op_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/lvp_seg_ptr.sv
module lvp_seg_ptr #(
  parameter int unsigned     IDX_W = 6,
  parameter logic [IDX_W-1:0] TAPS = 6'h30,
  parameter logic [IDX_W-1:0] SEED = 6'h01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] base_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam int unsigned SPAN_W = IDX_W + 1;

  logic [IDX_W-1:0]  ptr_q, raw, nxt;
  logic [SPAN_W-1:0] span, fold;

  always_comb begin
    raw  = (ptr_q == '0) ? IDX_W'(1) : {ptr_q[IDX_W-2:0], ^(ptr_q & TAPS)};
    span = (SPAN_W'(1) << IDX_W) - SPAN_W'(base_i);
    fold = SPAN_W'(raw) % span;
    // fold locked indices into [base, top]
    nxt  = (raw < base_i) ? (base_i + fold[IDX_W-1:0]) : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= SEED;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= nxt;
  end

  assign ptr_o = ptr_q;

  p_step_above_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> ptr_q >= $past(base_i));
  p_step_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && ($past(base_i) == '0 || 1'b1) |=> ptr_q != '0);
  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(ptr_q));
  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && step_i |=> ptr_q == $past(load_val_i));
endmodule

// File: rtl/lvp_side.sv
module lvp_side #(
  parameter int unsigned      NUM_SEG = 4,
  parameter int unsigned      IDX_W   = 6,
  parameter logic [IDX_W-1:0] TAPS    = 6'h30,
  parameter logic [IDX_W-1:0] SEED    = 6'h01,
  localparam int unsigned     SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_all_i,
  input  logic                     wr_seg_i,
  input  logic [SEG_W-1:0]         seg_sel_i,
  input  logic [IDX_W-1:0]         data_i,
  input  logic [NUM_SEG-1:0]       ev_i,
  output logic [IDX_W-1:0]         base_o,
  output logic [NUM_SEG*IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (wr_all_i) base_q <= data_i;
  end

  assign base_o = base_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic load;
    assign load = wr_all_i | (wr_seg_i & (seg_sel_i == SEG_W'(g)));

    lvp_seg_ptr #(.IDX_W(IDX_W), .TAPS(TAPS), .SEED(SEED)) u_ptr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .base_i     (base_q),
      .load_i     (load),
      .load_val_i (data_i),
      .step_i     (ev_i[g]),
      .ptr_o      (ptr_o[g*IDX_W +: IDX_W])
    );

    p_wr_all_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_all_i |=> ptr_o[g*IDX_W +: IDX_W] == base_o);
  end

  p_base_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_all_i |=> $stable(base_q));
endmodule

// File: rtl/lockdown_victim_ptr.sv
module lockdown_victim_ptr
  import lvp_pkg::*;
#(
  parameter int unsigned      NUM_SEG = 4,
  parameter int unsigned      IDX_W   = 6,
  parameter logic [IDX_W-1:0] TAPS    = 6'h30,
  parameter logic [IDX_W-1:0] SEED    = 6'h01,
  localparam int unsigned     SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned     NPTR    = NUM_SIDES * NUM_SEG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [1:0]            cmd_op_i,
  input  logic                  cmd_side_i,
  input  logic [SEG_W-1:0]      cmd_seg_i,
  input  logic [IDX_W-1:0]      cmd_data_i,
  input  logic                  test_mode_i,
  input  logic [NPTR-1:0]       fill_i,
  input  logic [NPTR-1:0]       cam_rd_i,
  output logic                  rd_valid_o,
  output logic [IDX_W-1:0]      rd_data_o,
  output logic [NPTR*IDX_W-1:0] victim_o
);
  logic [NPTR-1:0]  ev;
  logic [IDX_W-1:0] base_w [NUM_SIDES];
  logic             rd_cmd, rd_valid_q;
  logic [IDX_W-1:0] rd_data_q;

  // mode picks the only event source that may step
  assign ev     = test_mode_i ? cam_rd_i : fill_i;
  assign rd_cmd = cmd_valid_i && (cmd_op_i == OP_RD_BASE);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic sel;
    assign sel = cmd_valid_i && (cmd_side_i == 1'(s));

    lvp_side #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .TAPS(TAPS), .SEED(SEED)) u_side (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_all_i  (sel && (cmd_op_i == OP_WR_ALL)),
      .wr_seg_i  (sel && (cmd_op_i == OP_WR_SEG)),
      .seg_sel_i (cmd_seg_i),
      .data_i    (cmd_data_i),
      .ev_i      (ev[s*NUM_SEG +: NUM_SEG]),
      .base_o    (base_w[s]),
      .ptr_o     (victim_o[s*NUM_SEG*IDX_W +: NUM_SEG*IDX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_cmd;
      if (rd_cmd) rd_data_q <= base_w[cmd_side_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  p_rd_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> rd_valid_o);
  p_rd_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cmd |=> !rd_valid_o);
  p_test_ignores_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && !cmd_valid_i && cam_rd_i == '0 |=> $stable(victim_o));
  p_norm_ignores_cam_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i && !cmd_valid_i && fill_i == '0 |=> $stable(victim_o));
endmodule

// File: tb/lockdown_victim_ptr_tb_top.sv
`timescale 1ns/1ps
module lockdown_victim_ptr_tb_top;
  localparam int NSEG = 4;
  localparam int W    = 6;
  localparam int NP   = 2 * NSEG;
  localparam int TOP  = 1 << W;
  localparam int TAPS = 'h30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_side = 0, test_mode = 0;
  logic [1:0] cmd_op = 0;
  logic [1:0] cmd_seg = 0;
  logic [W-1:0] cmd_data = 0;
  logic [NP-1:0] fill = 0, cam_rd = 0;
  logic rd_valid;
  logic [W-1:0] rd_data;
  logic [NP*W-1:0] victim;

  int compared = 0, mismatched = 0;
  int mbase [2];
  int mptr [2][NSEG];
  string why [2][NSEG];
  bit mrdv;
  int mrdd;

  always #10 clk = ~clk;

  lockdown_victim_ptr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_side_i(cmd_side), .cmd_seg_i(cmd_seg), .cmd_data_i(cmd_data),
    .test_mode_i(test_mode), .fill_i(fill), .cam_rd_i(cam_rd),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .victim_o(victim));

  function automatic int raw_of(int p);
    if (p == 0) return 1;
    return ((p << 1) & (TOP - 1)) | ($countones(p & TAPS) & 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrdv = 0; mrdd = 0;
      for (int s = 0; s < 2; s++) begin
        mbase[s] = 0;
        for (int g = 0; g < NSEG; g++) begin mptr[s][g] = 1; why[s][g] = "R1"; end
      end
    end else begin
      mrdv = cmd_valid && cmd_op == 2'b00;
      if (mrdv) mrdd = mbase[cmd_side];
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < NSEG; g++) begin
          bit ev, other, ld;
          int r;
          ev    = test_mode ? cam_rd[s*NSEG+g] : fill[s*NSEG+g];
          other = test_mode ? fill[s*NSEG+g] : cam_rd[s*NSEG+g];
          ld    = cmd_valid && cmd_side == s &&
                  (cmd_op == 2'b01 || (cmd_op == 2'b10 && cmd_seg == g));
          if (ld) begin
            mptr[s][g] = cmd_data;
            why[s][g]  = ev ? "R9" : (cmd_op == 2'b01 ? "R3" : "R4");
          end else if (ev) begin
            r = raw_of(mptr[s][g]);
            if (r < mbase[s]) begin
              why[s][g] = "R8";
              r = mbase[s] + r % (TOP - mbase[s]);
            end else why[s][g] = (mptr[s][g] == 0) ? "R7" : (test_mode ? "R6" : "R5");
            mptr[s][g] = r;
          end else if (other) why[s][g] = test_mode ? "R6" : "R5";
        end
      if (cmd_valid && cmd_op == 2'b01) mbase[cmd_side] = cmd_data;
    end
  end

  function automatic int vic(int s, int g);
    return int'(victim[(s*NSEG+g)*W +: W]);
  endfunction

  task automatic chk(int act, int exp, string tag, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(rd_valid), int'(mrdv), "R2", "rd_valid");
    if (mrdv) chk(int'(rd_data), mrdd, "R2", "rd_data");
    for (int s = 0; s < 2; s++)
      for (int g = 0; g < NSEG; g++)
        chk(vic(s, g), mptr[s][g], why[s][g], $sformatf("victim s%0d g%0d", s, g));
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    compare_all();
    cmd_valid = 0; fill = 0; cam_rd = 0;
  endtask

  task automatic cmd(int op, int side, int seg, int data);
    cmd_valid = 1; cmd_op = 2'(op); cmd_side = 1'(side);
    cmd_seg = 2'(seg); cmd_data = W'(data);
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk(vic(s, 0), 1, "R1", "seed");
      chk(vic(s, NSEG-1), 1, "R1", "seed");
    end
    compare_all();
    cmd(0, 0, 0, 0); cyc();
    chk(int'(rd_data), 0, "R2", "reset base");
    // R7 zero escape and plain shift
    cmd(2, 0, 1, 0); cyc();
    fill[1] = 1; cyc();
    chk(vic(0, 1), 1, "R7", "zero escape");
    fill[1] = 1; cyc();
    chk(vic(0, 1), 2, "R7", "shift");
    // R3 then R8 fold
    cmd(1, 1, 0, 40); cyc();
    chk(vic(1, 2), 40, "R3", "all loaded");
    chk(vic(0, 2), 1, "R3", "other side");
    cmd(0, 1, 0, 0); cyc();
    chk(int'(rd_data), 40, "R2", "base read");
    for (int i = 0; i < 20; i++) begin fill[NSEG + (i % NSEG)] = 1; cyc(); end
    cmd(2, 1, 3, 5); cyc();
    chk(vic(1, 3), 5, "R4", "seg load below base");
    fill[NSEG+3] = 1; cyc();
    chk(vic(1, 3), 40 + 10 % 24, "R8", "fold");
    // R6 test mode
    test_mode = 1;
    fill = '1; cyc();
    cam_rd[0] = 1; cyc();
    // R9 collision
    cmd(2, 0, 0, 33); cam_rd[0] = 1; cyc();
    chk(vic(0, 0), 33, "R9", "load wins");
    cmd(1, 0, 0, 63); cyc();
    for (int i = 0; i < 8; i++) begin cam_rd = '1; cyc(); end
    cmd(3, 0, 0, 7); cyc();
    test_mode = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 300 == 150) test_mode = ~test_mode;
      if ($urandom_range(0, 9) < 3) begin
        int d;
        d = ($urandom_range(0, 1) == 1) ? $urandom_range(48, 63) : $urandom_range(0, 63);
        cmd($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3), d);
      end
      fill   = NP'($urandom) & NP'($urandom);
      cam_rd = NP'($urandom) & NP'($urandom);
      cyc();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule